// File: doc/BRIEF.md
# System Interrupt Controller with Group Mapping

This block gathers level-sensitive interrupt requests from peripherals and presents them to the processor core as nine group request lines. Inputs are arranged in banks of 32. A parameter sets the number of banks to one, two or three. Every input has a status bit that copies its level. Every input also has an enable bit in the bank's mask register. An input whose status and enable bits are both set is pending.

Each pending input drives one core group line. The line is chosen by a 4-bit routing field. Eight fields are packed into each 32-bit routing register, and each bank has four routing registers. A field value v selects core group 7+v. Output bit v of `grp_irq` carries group 7+v.

A small register port gives access to all registers. It takes an address, a write strobe, write data and an access size, and returns read data combinationally. Each bank also holds a wake register. The wake register is storage only.

Top module: `sic_top`

## Requirements
- R1: Each status bit copies its input level as sampled at the previous rising clock edge. It sets while the input is high and clears once the input is low, with no latching.
- R2: An input is pending only when its status bit and its mask bit are both 1. A cleared mask bit keeps that input off every group line.
- R3: Input n of a bank is routed by routing register n/8 of that bank, bits (n mod 8)*4+3 down to (n mod 8)*4. A field value v (0 to 8) drives `grp_irq[v]`, which stands for core group 7+v.
- R4: Each `grp_irq` bit is the OR of all pending inputs routed to it. It follows the status, mask and routing registers with no added register, so a register write takes effect on the outputs in the cycle after its clock edge.
- R5: A pending input whose field holds 9 to 15 reaches no group line.
- R6: Writes to a status register are ignored.
- R7: Mask, wake and routing registers take writes. A 32-bit write (`reg_size`=1) stores the whole word. A 16-bit write (`reg_size`=0) stores `reg_wdata[15:0]` with the upper half cleared.
- R8: Reset is synchronous and active low. It clears status and mask and sets every wake bit to 1. The routing registers of bank 0, in order 0 to 3, reset to 0x22211000, 0x43333332, 0x55555444 and 0x66655555. Bank 1 resets to 0x76543210, 0xFEDCBA98, 0x88888888 and 0x00000000. Bank 2 resets to 0x11111111 in all four registers.
- R9: Offsets 0x00 and 0x04 are 16-bit control words that read 0. Offset 0x08 reads the `RESET_VECTOR` parameter, zero-extended. Writes to these three offsets have no effect.
- R10: A read of an unmapped address returns 0. Unmapped addresses are misaligned addresses, holes in the map, and banks beyond the bank count. Every 16-bit read returns the register's low half with bits 31 to 16 at 0.
- R11: Bank k (k = 0, 1, 2) sits at base 0x40*(k+1). Within a bank, the mask is at +0x00, status at +0x04, wake at +0x08, and routing registers 0 to 3 at +0x10, +0x14, +0x18 and +0x1C.
- R12: Wake register contents have no effect on any group line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NB*32 | Peripheral interrupt levels, bank k in bits 32k+31:32k |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_size | input | 1 | Access size: 1 = 32-bit, 0 = 16-bit |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| grp_irq | output | 9 | Core group requests, bit v is group 7+v |

## Verification
The bench sweeps every input of both banks through all sixteen routing field values. A field decode with the wrong bit offset or register index would light the wrong line, and a missing range check would let values 9 to 15 wrap onto a real group. It changes the mask while inputs are held high, catching a design that latches status or ignores the enable bit. It writes to status registers, to the fixed control words and to unmapped addresses, where a loose decoder would corrupt state or return stale data. It also issues 16-bit accesses, where a design that failed to clear the upper half would leak data. A reset in the middle of the run and a wake-register write with inputs pending check that defaults return and that wake stays out of the forwarding path.

// File: rtl/sic_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt controller: bank geometry, field
// widths and the register address layout. Assumes an 8-bit byte address.
package sic_pkg;
    localparam int LANES       = 32;                 // inputs per bank
    localparam int FIELD_W     = 4;                  // routing field width
    localparam int FLD_PER_REG = 32 / FIELD_W;       // fields per routing register
    localparam int ROUTE_REGS  = LANES / FLD_PER_REG; // routing registers per bank
    localparam int NUM_GROUPS  = 9;                  // core group lines
    localparam int ADDR_W      = 8;
    localparam int BANK_SHIFT  = 6;                  // bank window size 64 bytes
    localparam int SEL_W       = ADDR_W - BANK_SHIFT;

    localparam logic [ADDR_W-1:0] ADR_SWRST = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_SYCFG = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_RVEC  = 8'h08;

    localparam logic [BANK_SHIFT-1:0] OFS_MASK   = 6'h00;
    localparam logic [BANK_SHIFT-1:0] OFS_STATUS = 6'h04;
    localparam logic [BANK_SHIFT-1:0] OFS_WAKE   = 6'h08;
    localparam logic [BANK_SHIFT-1:0] OFS_ROUTE  = 6'h10;

    typedef enum logic {ACC_16 = 1'b0, ACC_32 = 1'b1} acc_size_e;

    // Trim a word to the access size: 16-bit accesses keep the low half only.
    function automatic logic [31:0] fit_size(input logic [31:0] d, input logic sz);
        return (sz == ACC_32) ? d : {16'h0000, d[15:0]};
    endfunction
endpackage

// File: rtl/sic_bank.sv
`timescale 1ns/1ps
// One bank of controller state: status, mask, wake and routing registers.
// Assumes the caller has already qualified wr_en with the bank select and
// sized the write data. Status is not writable; it tracks irq_lvl.
module sic_bank
    import sic_pkg::*;
#(
    parameter logic [ROUTE_REGS*32-1:0] ROUTE_RST = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           irq_lvl,
    input  logic                       wr_en,
    input  logic [BANK_SHIFT-1:0]      ofs,
    input  logic [31:0]                wdata,
    output logic [LANES-1:0]           status_q,
    output logic [LANES-1:0]           mask_q,
    output logic [LANES-1:0]           wake_q,
    output logic [ROUTE_REGS*32-1:0]   rmap_q
);

    // Status register: sample input levels each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= irq_lvl;
    end

    // Mask register: cleared by reset, written at its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mask_q <= '0;
        else if (wr_en && ofs == OFS_MASK) mask_q <= wdata;
    end

    // Wake register: all ones by reset, plain storage otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wake_q <= '1;
        else if (wr_en && ofs == OFS_WAKE) wake_q <= wdata;
    end

    // Routing registers: one word per group of eight inputs.
    for (genvar r = 0; r < ROUTE_REGS; r++) begin : g_rmap
        localparam logic [BANK_SHIFT-1:0] MY_OFS = OFS_ROUTE + BANK_SHIFT'(r * 4);
        always_ff @(posedge clk) begin
            if (!rst_n)                      rmap_q[r*32 +: 32] <= ROUTE_RST[r*32 +: 32];
            else if (wr_en && ofs == MY_OFS) rmap_q[r*32 +: 32] <= wdata;
        end
    end

endmodule

// File: rtl/sic_route.sv
`timescale 1ns/1ps
// Combinational forwarding for one bank: each pending input raises the
// group line named by its 4-bit routing field. Field values at or above
// NUM_GROUPS raise nothing.
module sic_route
    import sic_pkg::*;
(
    input  logic [LANES-1:0]          status,
    input  logic [LANES-1:0]          mask,
    input  logic [ROUTE_REGS*32-1:0]  rmap,
    output logic [NUM_GROUPS-1:0]     grp_req
);

    logic [LANES-1:0]   pend;
    logic [FIELD_W-1:0] fld;

    // Gate status by mask, then OR each pending input into its group.
    always_comb begin
        pend    = status & mask;
        grp_req = '0;
        fld     = '0;
        for (int n = 0; n < LANES; n++) begin
            fld = rmap[(n / FLD_PER_REG) * 32 + (n % FLD_PER_REG) * FIELD_W +: FIELD_W];
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (pend[n] && int'(fld) == g) grp_req[g] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sic_rdmux.sv
`timescale 1ns/1ps
// Read-data multiplexer over the control words and all bank registers.
// Unmapped or misaligned addresses read zero; result is trimmed to size.
module sic_rdmux
    import sic_pkg::*;
#(
    parameter int          NB           = 1,
    parameter logic [15:0] RESET_VECTOR = 16'h0000
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         size,
    input  logic [NB*LANES-1:0]          status_all,
    input  logic [NB*LANES-1:0]          mask_all,
    input  logic [NB*LANES-1:0]          wake_all,
    input  logic [NB*ROUTE_REGS*32-1:0]  rmap_all,
    output logic [31:0]                  rdata
);

    logic [31:0]           raw;
    logic [BANK_SHIFT-1:0] ofs;
    logic [SEL_W-1:0]      sel;

    assign ofs = addr[BANK_SHIFT-1:0];
    assign sel = addr[ADDR_W-1:BANK_SHIFT];

    // Select the addressed register, zero when nothing matches.
    always_comb begin
        raw = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADR_RVEC) raw = {16'h0000, RESET_VECTOR};
            for (int k = 0; k < NB; k++) begin
                if (sel == SEL_W'(k + 1)) begin
                    if (ofs == OFS_MASK)   raw = mask_all[k*LANES +: LANES];
                    if (ofs == OFS_STATUS) raw = status_all[k*LANES +: LANES];
                    if (ofs == OFS_WAKE)   raw = wake_all[k*LANES +: LANES];
                    for (int r = 0; r < ROUTE_REGS; r++) begin
                        if (ofs == OFS_ROUTE + BANK_SHIFT'(r * 4))
                            raw = rmap_all[(k*ROUTE_REGS + r)*32 +: 32];
                    end
                end
            end
        end
        rdata = fit_size(raw, size);
    end

endmodule

// File: rtl/sic_top.sv
`timescale 1ns/1ps
// Interrupt controller top: NB banks of 32 level inputs, each forwarded to
// one of nine core group lines. Control words at 0x00/0x04 are inert;
// 0x08 reports RESET_VECTOR. Assumes NB is 1 to 3.
module sic_top
    import sic_pkg::*;
#(
    parameter int          NB           = 1,
    parameter logic [15:0] RESET_VECTOR = 16'hFFA0,
    parameter logic [3*ROUTE_REGS*32-1:0] ROUTE_RST = {
        32'h11111111, 32'h11111111, 32'h11111111, 32'h11111111,
        32'h00000000, 32'h88888888, 32'hFEDCBA98, 32'h76543210,
        32'h66655555, 32'h55555444, 32'h43333332, 32'h22211000}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NB*LANES-1:0]    irq_in,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_we,
    input  logic                   reg_size,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic [NUM_GROUPS-1:0]  grp_irq
);

    localparam int RW = ROUTE_REGS * 32;

    logic [NB*LANES-1:0]    status_all;
    logic [NB*LANES-1:0]    mask_all;
    logic [NB*LANES-1:0]    wake_all;
    logic [NB*RW-1:0]       rmap_all;
    logic [NUM_GROUPS-1:0]  grp_bank [NB];
    logic [31:0]            wdata_fit;

    assign wdata_fit = fit_size(reg_wdata, reg_size);

    for (genvar k = 0; k < NB; k++) begin : g_bank
        logic bank_wr;
        // Bank write strobe: aligned address inside this bank's window.
        assign bank_wr = reg_we && (reg_addr[1:0] == 2'b00) &&
                         (reg_addr[ADDR_W-1:BANK_SHIFT] == SEL_W'(k + 1));

        sic_bank #(.ROUTE_RST(ROUTE_RST[k*RW +: RW])) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_lvl  (irq_in[k*LANES +: LANES]),
            .wr_en    (bank_wr),
            .ofs      (reg_addr[BANK_SHIFT-1:0]),
            .wdata    (wdata_fit),
            .status_q (status_all[k*LANES +: LANES]),
            .mask_q   (mask_all[k*LANES +: LANES]),
            .wake_q   (wake_all[k*LANES +: LANES]),
            .rmap_q   (rmap_all[k*RW +: RW])
        );

        sic_route route_i (
            .status  (status_all[k*LANES +: LANES]),
            .mask    (mask_all[k*LANES +: LANES]),
            .rmap    (rmap_all[k*RW +: RW]),
            .grp_req (grp_bank[k])
        );
    end

    // Merge the per-bank group requests.
    always_comb begin
        grp_irq = '0;
        for (int k = 0; k < NB; k++) grp_irq = grp_irq | grp_bank[k];
    end

    sic_rdmux #(.NB(NB), .RESET_VECTOR(RESET_VECTOR)) rdmux_i (
        .addr       (reg_addr),
        .size       (reg_size),
        .status_all (status_all),
        .mask_all   (mask_all),
        .wake_all   (wake_all),
        .rmap_all   (rmap_all),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/sic_checker.sv
`timescale 1ns/1ps
// Protocol and state checks for sic_top, attached by bind below.
// Assumes bank 0 sits at 0x40 (mask) and 0x48 (wake).
module sic_checker
    import sic_pkg::*;
#(
    parameter int NB = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NB*LANES-1:0]    irq_in,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_we,
    input logic                   reg_size,
    input logic [31:0]            reg_wdata,
    input logic [31:0]            reg_rdata,
    input logic [NUM_GROUPS-1:0]  grp_irq,
    input logic [NB*LANES-1:0]    status_all,
    input logic [NB*LANES-1:0]    mask_all,
    input logic [NB*LANES-1:0]    wake_all
);

    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> status_all == $past(irq_in));                              // R1

    AST_PEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_irq != '0 |-> (status_all & mask_all) != '0);                   // R2

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (grp_irq == '0 && mask_all == '0 && wake_all == '1)); // R8

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h40 && reg_size) |=> mask_all[31:0] == $past(reg_wdata)); // R7

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 8'h48) |=> $stable(wake_all[31:0]));        // R7

    AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[1:0] != 2'b00 |-> reg_rdata == 32'h0);                     // R10

    AST_HALF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_size |-> reg_rdata[31:16] == 16'h0);                           // R10

endmodule

bind sic_top sic_checker #(.NB(NB)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_size   (reg_size),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .grp_irq    (grp_irq),
    .status_all (status_all),
    .mask_all   (mask_all),
    .wake_all   (wake_all)
);

// File: tb/sic_top_tb_top.sv
`timescale 1ns/1ps
module sic_top_tb_top;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*32-1:0] irq_in = '0;
    logic [7:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic          reg_size = 1'b1;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [8:0]    grp_irq;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R8";
    bit    done = 1'b0;

    always #5 clk = ~clk; // 100 MHz

    sic_top #(.NB(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .grp_irq(grp_irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_status [NB];
    logic [31:0] m_mask   [NB];
    logic [31:0] m_wake   [NB];
    logic [31:0] m_rmap   [NB*4];

    function automatic logic [31:0] def_rmap(int idx);
        case (idx)
            0: return 32'h22211000; 1: return 32'h43333332;
            2: return 32'h55555444; 3: return 32'h66655555;
            4: return 32'h76543210; 5: return 32'hFEDCBA98;
            6: return 32'h88888888; 7: return 32'h00000000;
            default: return 32'h11111111;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                m_status[b] = '0; m_mask[b] = '0; m_wake[b] = '1;
                for (int r = 0; r < 4; r++) m_rmap[b*4+r] = def_rmap(b*4+r);
            end
        end else begin
            int b;
            int o;
            logic [31:0] d;
            b = int'(reg_addr[7:6]) - 1;
            o = int'(reg_addr[5:0]);
            d = reg_size ? reg_wdata : {16'h0, reg_wdata[15:0]};
            if (reg_we && reg_addr[1:0] == 2'b00 && b >= 0 && b < NB) begin
                if (o == 0) m_mask[b] = d;
                else if (o == 8) m_wake[b] = d;
                else if (o >= 16 && o <= 28) m_rmap[b*4 + (o-16)/4] = d;
            end
            for (int k = 0; k < NB; k++) m_status[k] = irq_in[k*32 +: 32];
        end
    end

    function automatic logic [8:0] exp_grp();
        logic [8:0] g;
        g = '0;
        for (int b = 0; b < NB; b++)
            for (int n = 0; n < 32; n++) begin
                int f;
                f = int'((m_rmap[b*4 + n/8] >> ((n%8)*4)) & 32'hF);
                if (m_status[b][n] && m_mask[b][n] && f < 9) g[f] = 1'b1;
            end
        return g;
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a, logic sz);
        logic [31:0] v;
        int b;
        int o;
        v = '0;
        b = int'(a[7:6]) - 1;
        o = int'(a[5:0]);
        if (a[1:0] == 2'b00) begin
            if (a == 8'h08) v = 32'h0000FFA0;
            else if (b >= 0 && b < NB) begin
                if (o == 0) v = m_mask[b];
                else if (o == 4) v = m_status[b];
                else if (o == 8) v = m_wake[b];
                else if (o >= 16 && o <= 28) v = m_rmap[b*4 + (o-16)/4];
            end
        end
        return sz ? v : {16'h0, v[15:0]};
    endfunction

    // ---------------- checking ----------------
    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of both outputs against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({23'h0, grp_irq}, {23'h0, exp_grp()}, cur_tag);
            check(reg_rdata, exp_rd(reg_addr, reg_size), cur_tag);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(logic [7:0] a, logic [31:0] d, logic sz);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
        @(posedge clk); #2;
        reg_we = 1'b0; reg_size = 1'b1;
    endtask

    task automatic rd(logic [7:0] a, logic sz, logic [31:0] exp, string tag);
        @(posedge clk); #2;
        reg_addr = a; reg_size = sz;
        @(negedge clk);
        check(reg_rdata, exp, tag);
        reg_size = 1'b1;
    endtask

    task automatic drive(logic [NB*32-1:0] v);
        @(posedge clk); #2;
        irq_in = v;
        @(posedge clk); #2;
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst_n = 1'b0;
        repeat (2) @(posedge clk); #2; rst_n = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        do_reset();

        // R8 reset values, R11 bank placement
        cur_tag = "R8";
        rd(8'h40, 1, 32'h0, "R8");
        rd(8'h44, 1, 32'h0, "R8");
        rd(8'h48, 1, 32'hFFFFFFFF, "R8");
        rd(8'h50, 1, 32'h22211000, "R8");
        rd(8'h5C, 1, 32'h66655555, "R8");
        rd(8'h94, 1, 32'hFEDCBA98, "R11");
        check({23'h0, grp_irq}, 32'h0, "R8");

        // R9 control words
        cur_tag = "R9";
        wr(8'h00, 32'hFFFFFFFF, 1); wr(8'h04, 32'h1234, 0); wr(8'h08, 32'h5555, 1);
        rd(8'h00, 0, 32'h0, "R9");
        rd(8'h04, 1, 32'h0, "R9");
        rd(8'h08, 1, 32'h0000FFA0, "R9");

        // R1 status follows level, R6 status read-only
        cur_tag = "R1";
        drive({32'h0, 32'hA5A50001});
        rd(8'h44, 1, 32'hA5A50001, "R1");
        wr(8'h44, 32'h0F0F0F0F, 1);
        cur_tag = "R6";
        rd(8'h44, 1, 32'hA5A50001, "R6");
        drive('0);
        rd(8'h44, 1, 32'h0, "R1");

        // R7 writes, sizes; R11 bank 1
        cur_tag = "R7";
        wr(8'h40, 32'h12345678, 1);
        rd(8'h40, 1, 32'h12345678, "R7");
        wr(8'h40, 32'hDEADBEEF, 0);
        rd(8'h40, 1, 32'h0000BEEF, "R7");
        wr(8'h48, 32'hCAFEF00D, 1);
        rd(8'h48, 0, 32'h0000F00D, "R10");
        wr(8'h54, 32'h01020304, 1);
        rd(8'h54, 1, 32'h01020304, "R7");
        wr(8'h80, 32'h87654321, 1);
        rd(8'h80, 1, 32'h87654321, "R11");
        rd(8'h40, 1, 32'h0000BEEF, "R11");

        // R10 unmapped reads
        cur_tag = "R10";
        rd(8'h0C, 1, 32'h0, "R10");
        rd(8'h42, 1, 32'h0, "R10");
        rd(8'h4C, 1, 32'h0, "R10");
        rd(8'h60, 0, 32'h0, "R10");
        wr(8'hC0, 32'hFFFFFFFF, 1);
        rd(8'hC0, 1, 32'h0, "R10");

        // R3/R5 exhaustive route sweep
        wr(8'h40, 32'hFFFFFFFF, 1);
        wr(8'h80, 32'hFFFFFFFF, 1);
        for (int b = 0; b < NB; b++) begin
            for (int n = 0; n < 32; n++) begin
                for (int f = 0; f < 16; f++) begin
                    logic [31:0] w;
                    logic [NB*32-1:0] v;
                    w = 32'hFFFFFFFF;
                    w[(n%8)*4 +: 4] = 4'(f);
                    cur_tag = (f < 9) ? "R3" : "R5";
                    wr(8'((b+1)*64 + 16 + (n/8)*4), w, 1);
                    v = '0; v[b*32+n] = 1'b1;
                    drive(v);
                    @(negedge clk);
                    check({23'h0, grp_irq}, (f < 9) ? (32'h1 << f) : 32'h0, cur_tag);
                    irq_in = '0;
                end
            end
        end

        // restore defaults, then R2 mask gating and R4 immediate effect
        do_reset();
        cur_tag = "R2";
        wr(8'h40, 32'hFFFFFFFF, 1);
        drive({32'h0, 32'h00000044});     // inputs 2 (field 0) and 6 (field 2)
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h005, "R2");
        wr(8'h40, 32'h00000040, 1);
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h004, "R4");
        wr(8'h40, 32'h0, 1);
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h000, "R2");
        cur_tag = "R4";
        wr(8'h80, 32'h00000300, 1);        // bank 1 inputs 8,9 fields 8,9
        drive({32'h00000300, 32'h00000044});
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h100, "R4");
        wr(8'h40, 32'hFFFFFFFF, 1);
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h105, "R4");

        // R12 wake has no effect
        cur_tag = "R12";
        wr(8'h48, 32'h0, 1);
        wr(8'h88, 32'h0, 1);
        @(negedge clk);
        check({23'h0, grp_irq}, 32'h105, "R12");

        // assorted patterns under model compare
        cur_tag = "R2";
        for (int i = 0; i < 20; i++) begin
            wr(8'h40, 32'h9E3779B9 * (i + 1), 1);
            drive({32'h7F4A7C15 * (i + 3), 32'hB5297A4D ^ (32'h01010101 << i)});
        end

        // mid-run reset returns defaults
        cur_tag = "R8";
        do_reset();
        rd(8'h48, 1, 32'hFFFFFFFF, "R8");
        rd(8'h40, 1, 32'h0, "R8");
        rd(8'h98, 1, 32'h88888888, "R8");
        irq_in = '0;
        repeat (3) @(posedge clk);
        #2 done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule